// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment-Based Select Paths

This block adds two unsigned operands of equal width plus a single carry-in bit. It returns the sum at full operand width and a carry-out. The block is purely combinational, so a result is valid in the same cycle as its operands.

The word is cut into slices whose widths grow from the least significant end. For the default 16-bit word the slices are 2, 2, 3, 4 and 5 bits wide. The lowest slice is an ordinary ripple adder fed by the external carry-in.

Every higher slice adds its operand bits once, with a carry-in of zero. It then forms the carry-in-one answer by incrementing that result with a small XOR/AND incrementer, which is cheaper than a second ripple adder. The real carry arriving from the slice below then picks one of the two answers. Wider words are built by appending slices that are each one bit wider than the previous one, with the last slice cut short to fit.

Top module: `csa_sqrt_adder`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum} equals a + b + carry_in, taken as an unsigned value one bit wider than the operands.
- R2: With WIDTH=16 the slices cover bits [1:0], [3:2], [6:4], [10:7] and [15:11]. For other widths, slices after the second grow by one bit each and the last is truncated. A carry generated at any slice boundary must reach the bit above it.
- R3: The lowest slice is a ripple adder that takes the external carry-in directly. Its carry-out selects the result of the slice covering the next bits.
- R4: The incrementer in an n-bit upper slice is n+1 bits wide and returns its input plus one, modulo 2^(n+1). An all-ones input returns all zeros.
- R5: When the carry arriving at an upper slice is 0, the slice outputs its carry-in-zero sum and carry unchanged. When that carry is 1, it outputs the incremented value.
- R6: When an upper slice's carry-in-zero sum bits are all ones with no carry, and a carry arrives, the slice outputs zero sum bits and a carry of 1 to the next slice. For example, 0xFFFF + 0 + 1 gives sum 0x0000 and carry-out 1.
- R7: The most significant slice supplies the top sum bits and the block's carry-out. For example, 0xF800 + 0x0800 gives sum 0x0000 and carry-out 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First unsigned operand |
| op_b | input | WIDTH | Second unsigned operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| carry_out | output | 1 | Carry out of the most significant bit |

## Verification
Both sum and carry-out come from combinational logic only, so each result is due in the same cycle its operands are applied, with no register in the path. The bench applies new operands just after a falling clock edge and samples the outputs one nanosecond later, well before the next rising edge. Every comparison therefore sees settled values from the current stimulus. Expected values are formed by plain wide integer addition in the bench.

// File: rtl/csa_pkg.sv
// Package csa_pkg
// Slice geometry for the square-root carry-select adder. Nominal slice
// widths are 2, 2, 3, 4, 5, ... from the least significant end; the last
// slice is truncated to the word. Assumes total widths of at least 1.
package csa_pkg;

    localparam int MAX_SLICES = 64;

    // Nominal (untruncated) width of slice idx.
    function automatic int nom_width(input int idx);
        return (idx < 2) ? 2 : idx + 1;
    endfunction

    // Lowest bit position covered by slice idx.
    function automatic int slice_base(input int idx);
        int acc;
        acc = 0;
        for (int j = 0; j < MAX_SLICES; j++)
            if (j < idx) acc += nom_width(j);
        return acc;
    endfunction

    // Actual width of slice idx inside a word of total bits.
    function automatic int slice_width(input int total, input int idx);
        int rem;
        rem = total - slice_base(idx);
        if (rem <= 0) return 0;
        return (rem < nom_width(idx)) ? rem : nom_width(idx);
    endfunction

    // Number of slices needed to cover total bits.
    function automatic int slice_count(input int total);
        int n;
        n = 0;
        for (int j = 0; j < MAX_SLICES; j++)
            if (slice_width(total, j) > 0) n++;
        return n;
    endfunction

endpackage

// File: rtl/csa_ripple.sv
// Module csa_ripple
// W-bit ripple-carry adder. With ZERO_CIN=1 the carry-in is assumed to be
// tied low and bit 0 is a half adder; otherwise every bit is a full adder.
module csa_ripple #(
    parameter int W        = 4,
    parameter bit ZERO_CIN = 1'b0
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W:0] cy;

    generate
        if (ZERO_CIN) begin : g_half_lsb
            // Half adder at bit 0; incoming carry is known to be zero.
            assign s[0]  = a[0] ^ b[0];
            assign cy[1] = a[0] & b[0];
            assign cy[0] = 1'b0;
        end else begin : g_full_lsb
            // Full adder at bit 0 fed by the external carry.
            assign cy[0] = ci;
            assign s[0]  = a[0] ^ b[0] ^ cy[0];
            assign cy[1] = (a[0] & b[0]) | (cy[0] & (a[0] ^ b[0]));
        end

        for (genvar i = 1; i < W; i++) begin : g_bit
            // Full adder for bit i.
            assign s[i]    = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
        end
    endgenerate

    assign co = cy[W];

    // Arithmetic checks on the ripple result.
    always_comb begin
        AST_RIPPLE_ARITH: assert ({co, s} == ((W+1)'(a) + (W+1)'(b) + (W+1)'(ZERO_CIN ? 1'b0 : ci)))
            else $error("ripple result mismatch"); // R3
        AST_HALF_CIN: assert (!ZERO_CIN || !ci)
            else $error("half-adder slice given nonzero carry"); // R2
    end

endmodule

// File: rtl/csa_excess1.sv
// Module csa_excess1
// W-bit binary-to-excess-one converter: y = x + 1 modulo 2^W, built as an
// XOR/AND incrementer chain. Assumes W >= 2.
module csa_excess1 #(
    parameter int W = 3
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);

    // all_low[i] is 1 when x[i:0] are all ones.
    logic [W-2:0] all_low;

    assign y[0]       = ~x[0];
    assign all_low[0] = x[0];

    generate
        for (genvar i = 1; i < W; i++) begin : g_inc
            // Toggle bit i when every lower bit is one.
            assign y[i] = x[i] ^ all_low[i-1];
            if (i < W - 1) begin : g_chain
                // Extend the all-ones chain.
                assign all_low[i] = all_low[i-1] & x[i];
            end
        end
    endgenerate

    // Converter must equal an increment with wrap.
    always_comb begin
        AST_INC_WRAP: assert (y == W'(x + W'(1)))
            else $error("incrementer mismatch"); // R4
    end

endmodule

// File: rtl/csa_select_slice.sv
// Module csa_select_slice
// One upper slice: a carry-in-zero ripple adder, an (W+1)-bit incrementer
// on its {carry, sum}, and a 2:1 select driven by the carry from below.
module csa_select_slice #(
    parameter int W = 3
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);

    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [W:0]   s_one;

    csa_ripple #(.W(W), .ZERO_CIN(1'b1)) u_rca (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_zero),
        .co (c_zero)
    );

    csa_excess1 #(.W(W + 1)) u_inc (
        .x ({c_zero, s_zero}),
        .y (s_one)
    );

    // Pick the carry-in-one or carry-in-zero result.
    always_comb begin
        {co, s} = sel ? s_one : {c_zero, s_zero};
    end

    // Slice output is the zero-carry result offset by the select bit.
    always_comb begin
        AST_SLICE_SELECT: assert ({co, s} == (W+1)'({c_zero, s_zero} + (W+1)'(sel)))
            else $error("slice select mismatch"); // R5
        AST_SLICE_ROLLOVER: assert (!(sel && (&s_zero) && !c_zero) || ({co, s} == {1'b1, {W{1'b0}}}))
            else $error("slice rollover mismatch"); // R6
    end

endmodule

// File: rtl/csa_sqrt_adder.sv
// Module csa_sqrt_adder
// Unsigned WIDTH-bit carry-select adder with square-root slice sizing.
// Slice 0 is a plain ripple adder on carry_in; every higher slice uses
// csa_select_slice, chained through the slice carries. Combinational.
module csa_sqrt_adder #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    localparam int NSLICE = csa_pkg::slice_count(WIDTH);

    // slice_cy[k] is the carry into slice k.
    logic [NSLICE:0] slice_cy;

    assign slice_cy[0] = carry_in;

    generate
        for (genvar k = 0; k < NSLICE; k++) begin : g_slice
            localparam int SW = csa_pkg::slice_width(WIDTH, k);
            localparam int SB = csa_pkg::slice_base(k);
            if (k == 0) begin : g_low
                csa_ripple #(.W(SW), .ZERO_CIN(1'b0)) u_low (
                    .a  (op_a[SB +: SW]),
                    .b  (op_b[SB +: SW]),
                    .ci (slice_cy[0]),
                    .s  (sum[SB +: SW]),
                    .co (slice_cy[1])
                );
            end else begin : g_upper
                csa_select_slice #(.W(SW)) u_sel (
                    .a   (op_a[SB +: SW]),
                    .b   (op_b[SB +: SW]),
                    .sel (slice_cy[k]),
                    .s   (sum[SB +: SW]),
                    .co  (slice_cy[k+1])
                );
            end
        end
    endgenerate

    assign carry_out = slice_cy[NSLICE];

    // Whole-word result against a behavioural sum.
    always_comb begin
        AST_WORD_SUM: assert ({carry_out, sum} == ((WIDTH+1)'(op_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in)))
            else $error("word sum mismatch"); // R1
        AST_TOP_CARRY: assert (carry_out == (((WIDTH+1)'(op_a) + (WIDTH+1)'(op_b) + (WIDTH+1)'(carry_in)) >> WIDTH))
            else $error("carry out mismatch"); // R7
    end

endmodule

// File: tb/csa_sqrt_adder_bench.sv
// Bench for csa_sqrt_adder: directed and random at 16 bits, exhaustive at
// 6 bits, random at 40 bits. Expected values by wide integer addition.
module csa_sqrt_adder_bench;

    logic clk;
    logic rst_n;
    int   n_checks;
    int   n_fail;
    bit   done;

    logic [15:0] a16, b16, s16;
    logic        c16, co16;
    logic [5:0]  a6, b6, s6;
    logic        c6, co6;
    logic [39:0] a40, b40, s40;
    logic        c40, co40;

    csa_sqrt_adder #(.WIDTH(16)) u_csa_sqrt_adder (
        .op_a(a16), .op_b(b16), .carry_in(c16), .sum(s16), .carry_out(co16));
    csa_sqrt_adder #(.WIDTH(6)) u_csa_sqrt_adder_w6 (
        .op_a(a6), .op_b(b6), .carry_in(c6), .sum(s6), .carry_out(co6));
    csa_sqrt_adder #(.WIDTH(40)) u_csa_sqrt_adder_w40 (
        .op_a(a40), .op_b(b40), .carry_in(c40), .sum(s40), .carry_out(co40));

    // 125 MHz clock.
    initial clk = 1'b0;
    always #4 clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one 16-bit vector and compare sum and carry separately.
    task automatic run16(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] e;
        @(negedge clk);
        a16 = a; b16 = b; c16 = c;
        #1;
        e = 17'(a) + 17'(b) + 17'(c);
        check({req, " sum"}, 64'(s16), 64'(e[15:0]));
        check({req, " carry"}, 64'(co16), 64'(e[16]));
    endtask

    task automatic run6(input logic [5:0] a, input logic [5:0] b, input logic c);
        logic [6:0] e;
        a6 = a; b6 = b; c6 = c;
        #1;
        e = 7'(a) + 7'(b) + 7'(c);
        check("R1 w6", 64'({co6, s6}), 64'(e));
    endtask

    task automatic run40(input logic [39:0] a, input logic [39:0] b, input logic c);
        logic [40:0] e;
        @(negedge clk);
        a40 = a; b40 = b; c40 = c;
        #1;
        e = 41'(a) + 41'(b) + 41'(c);
        check("R2 w40 extension", 64'({co40, s40}), 64'(e));
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Main stimulus sequence.
    initial begin
        n_checks = 0; n_fail = 0; done = 1'b0;
        a16 = '0; b16 = '0; c16 = 1'b0;
        a6 = '0; b6 = '0; c6 = 1'b0;
        a40 = '0; b40 = '0; c40 = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset sum", 64'(s16), 64'd0);
        check("R1 reset carry", 64'(co16), 64'd0);
        rst_n = 1'b1;

        run16("R3 cin into low slice", 16'h0003, 16'h0000, 1'b1);
        run16("R3 low slice carry select", 16'h0003, 16'h0001, 1'b0);
        run16("R2 boundary bit3", 16'h000F, 16'h0001, 1'b0);
        run16("R2 boundary bit6", 16'h007F, 16'h0001, 1'b0);
        run16("R2 boundary bit10", 16'h07FF, 16'h0001, 1'b0);
        run16("R4 R6 slice [6:4] rollover", 16'h007F, 16'h0000, 1'b1);
        run16("R5 select zero path", 16'h0070, 16'h0000, 1'b0);
        run16("R5 select one path", 16'h0070, 16'h000F, 1'b1);
        run16("R6 full word rollover", 16'hFFFF, 16'h0000, 1'b1);
        run16("R7 top slice carry", 16'hF800, 16'h0800, 1'b0);
        run16("R7 max operands", 16'hFFFF, 16'hFFFF, 1'b1);
        run16("R4 slice [10:7] ones", 16'h0780, 16'h0000, 1'b1);

        // Exhaustive 6-bit sweep (slices 2,2,2).
        for (int x = 0; x < 64; x++) begin
            @(negedge clk);
            for (int y = 0; y < 64; y++)
                for (int c = 0; c < 2; c++)
                    run6(6'(x), 6'(y), c[0]);
        end

        // Random 16-bit vectors.
        for (int i = 0; i < 2000; i++)
            run16("R1 random16", 16'($urandom), 16'($urandom), 1'($urandom));

        // Random 40-bit vectors over the extended slice chain.
        for (int i = 0; i < 1000; i++)
            run40({8'($urandom), 32'($urandom)}, {8'($urandom), 32'($urandom)}, 1'($urandom));
        run40({40{1'b1}}, 40'd0, 1'b1);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule